// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands, by default 32 bits each, and returns their full signed product, twice the operand width. It works over several clock cycles. Each cycle it retires two bits of the multiplier. It does this by recoding a three-bit window of the multiplier into a signed digit, then adding the matching multiple of the multiplicand into a running partial product. The partial product then shifts right arithmetically by two places.

A client pulses `start` while the block is idle, with both operands on the input pins. The block raises `busy` for W/2 cycles. It then pulses `done` for one cycle, and from that cycle on `product` holds the result. The result stays on the pins until the next accepted start. A start that arrives while `busy` is high is dropped.

Top module: `booth_radix4_mul`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` that is sampled while `busy` is 0 captures `mcand` and `mplier`, and `busy` is 1 from the next cycle on.
- R3: `busy` stays high for exactly W/2 cycles after the accepting edge. `done` is 1 for exactly the single cycle after `busy` falls, and it is never 1 together with `busy`.
- R4: When `done` is 1, `product` equals the exact signed product of the captured operands, sign-extended to 2W bits.
- R5: Corner operands give exact results. The most negative value squared gives 2^(2W-2). Other corners are the most negative value times the most positive value, -1 times -1, and either operand zero.
- R6: A `start` sampled while `busy` is 1 is ignored. The operands on the pins at that time have no effect on the running result.
- R7: While the block is idle and no start is sampled, `product` does not change.
- R8: Each step recodes the window (b[i+1], b[i], b[i-1]) into a digit, with b[-1] = 0 on the first step. The windows 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. The digit times the multiplicand is added before the two-place shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2W | Signed product, held until the next start |

## Verification
The edge that accepts a start makes `busy` visible one cycle later. `busy` then stays high for 16 cycles, and `done` and the final `product` appear 16 cycles after the accepting edge. The bench runs a behavioural model that steps on each rising edge, using a countdown and a full-width signed multiply. It compares `busy`, `done` and, whenever the model is idle, `product` at every falling edge. The operand sets cover corner values, multipliers that produce every recoding window, random pairs, a start raised mid-run, and a start raised in the same cycle as `done`.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } digit_e;

    // Booth window {upper, lower, right neighbour} -> signed digit (R8)
    function automatic digit_e recode_window(input logic [2:0] win);
        digit_e d;
        case (win)
            3'b001, 3'b010: d = DIG_POS1;
            3'b011:         d = DIG_POS2;
            3'b100:         d = DIG_NEG2;
            3'b101, 3'b110: d = DIG_NEG1;
            default:        d = DIG_ZERO;
        endcase
        return d;
    endfunction

    typedef struct packed {
        logic neg;   // subtract the multiple
        logic dbl;   // use twice the multiplicand
        logic nz;    // multiple is non-zero
    } mult_sel_t;

    function automatic mult_sel_t digit_to_sel(input digit_e d);
        mult_sel_t s;
        s.neg = (d == DIG_NEG1) || (d == DIG_NEG2);
        s.dbl = (d == DIG_POS2) || (d == DIG_NEG2);
        s.nz  = (d != DIG_ZERO);
        return s;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [1:0] pair,
    input  logic       right_bit,
    output mult_sel_t  sel
);
    digit_e digit;

    always_comb begin
        digit = recode_window({pair, right_bit});
        sel   = digit_to_sel(digit);
    end
endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W+1:0] part_in,
    input  logic [W-1:0] mcand,
    input  mult_sel_t    sel,
    output logic [W+1:0] part_out
);
    localparam int HW = W + 2;

    logic [HW-1:0] ext;
    logic [HW-1:0] mult;
    logic [HW-1:0] addend;

    always_comb begin
        ext = {{2{mcand[W-1]}}, mcand};
        if (!sel.nz)
            mult = '0;
        else if (sel.dbl)
            mult = {ext[HW-2:0], 1'b0};
        else
            mult = ext;
        addend   = sel.neg ? ~mult : mult;
        part_out = part_in + addend + HW'(sel.neg);
    end
endmodule

// File: rtl/booth_seq.sv
module booth_seq #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0] cnt;

    assign load = start && !busy;
    assign step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/booth_radix4_mul.sv
module booth_radix4_mul
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int HW    = W + 2;
    localparam int STEPS = W / 2;

    logic          load, step;
    logic [HW-1:0] hi, hi_sum;
    logic [W-1:0]  lo, mc_q;
    logic          prev;
    mult_sel_t     sel;

    booth_seq #(.STEPS(STEPS)) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .busy(busy), .done(done)
    );

    booth_recoder rec_i (
        .pair(lo[1:0]), .right_bit(prev), .sel(sel)
    );

    booth_step #(.W(W)) add_i (
        .part_in(hi), .mcand(mc_q), .sel(sel), .part_out(hi_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi   <= '0;
            lo   <= '0;
            prev <= 1'b0;
            mc_q <= '0;
        end else if (load) begin
            hi   <= '0;
            lo   <= mplier;
            prev <= 1'b0;
            mc_q <= mcand;
        end else if (step) begin
            hi   <= {{2{hi_sum[HW-1]}}, hi_sum[HW-1:2]};
            lo   <= {hi_sum[1:0], lo[W-1:2]};
            prev <= lo[1];
        end
    end

    assign product = {hi[W-1:0], lo};

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
    assert_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mc_q));
endmodule

// File: tb/booth_radix4_mul_tb_top.sv
module booth_radix4_mul_tb_top;
    localparam int W     = 32;
    localparam int STEPS = W / 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string cur_tag = "R4";

    // behavioural reference state
    bit             m_busy = 1'b0;
    bit             m_done = 1'b0;
    int             m_left = 0;
    logic [2*W-1:0] m_pend = '0;
    logic [2*W-1:0] m_prod = '0;

    always #10 clk = ~clk;

    booth_radix4_mul #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_left = 0; m_prod = '0;
        end else begin
            m_done = 1'b0;
            if (!m_busy && start) begin
                m_busy = 1'b1;
                m_left = STEPS;
                m_pend = $signed({{W{mcand[W-1]}}, mcand}) *
                         $signed({{W{mplier[W-1]}}, mplier});
            end else if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_prod = m_pend;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == m_busy, "R2 busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R3 done", 64'(done), 64'(m_done));
            if (!m_busy)
                chk(product == m_prod, cur_tag, product, m_prod);
        end
    end

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        while (m_busy) @(negedge clk);
        cur_tag = tag;
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mcand = $urandom; mplier = $urandom;
        while (!m_done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags", {busy, done}, 0);
        chk(product == '0, "R1 product", product, '0);

        run(32'd7, 32'd2, "R4 small");
        run(32'hFFFF_FFFD, 32'd5, "R4 neg x pos");
        run(32'h8000_0000, 32'h8000_0000, "R5 min*min");
        run(32'h8000_0000, 32'h7FFF_FFFF, "R5 min*max");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 -1*-1");
        run(32'h0, 32'h8000_0000, "R5 zero");
        run(32'h1234_5678, 32'h0, "R5 zero mplier");
        run(32'h7FFF_FFFF, 32'h5555_5555, "R8 0101 windows");
        run(32'h8000_0001, 32'hAAAA_AAAA, "R8 1010 windows");
        run(32'h0BAD_CAFE, 32'h3333_3333, "R8 0011 windows");
        run(32'hDEAD_BEEF, 32'hCCCC_CCCC, "R8 1100 windows");
        run(32'hFFFF_FF01, 32'h0F0F_F0F1, "R8 mixed runs");
        for (int i = 0; i < 6; i++) run($urandom, $urandom, "R4 random");

        // R6: start raised mid-run with other operands
        @(negedge clk);
        cur_tag = "R6 ignored start";
        mcand = 32'd12345; mplier = 32'hFFFF_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        mcand = 32'h7FFF_FFFF; mplier = 32'h7FFF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);

        // R7: idle hold, then start in the same cycle as done
        repeat (8) @(negedge clk);
        cur_tag = "R7 hold";
        mcand = 32'd3; mplier = 32'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        cur_tag = "R2 back-to-back";
        mcand = 32'hFFFF_FFF0; mplier = 32'd100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule